// File: doc/BRIEF.md
# Data-Lane Low-Power Escape Sequencer

This block drives the low-power line states of a two-lane serial display link. Each host command moves the lanes from one resting state to another through an exact, ordered run of line states. It covers escape-mode entry and exit, entry into and exit from high-speed transmission, and the bus turnaround request. Every line state holds for a programmable number of cycles, so one design can serve several link rates.

Once lane 0 is in escape mode, the block shifts out an eight-bit entry code. Each bit occupies one bit slot and is marked by a strobe; the spaced-one-hot wire coding is left to the stage that follows. The low-power data command then streams payload bytes from a valid/ready source. The ultra-low power command parks the lane until a wake command arrives. The two trigger commands leave escape mode as soon as their code has been sent.

The host pulses `cmd_start` with a mode. A command is accepted only from the resting state it belongs to. Completion is signalled by a one-cycle `cmd_done`, and a rejected command by a one-cycle `cmd_err`.

Top module: `lane_esc_seq`

## Requirements
- R1: After reset both lanes show LP-11 (dp=1, dn=0 is LP-10; dp,dn written as "LP-dpdn"), with hs and hiz low, and cmd_done, cmd_err, tx_ready and bit_strobe all low.
- R2: Every line state and every bit slot lasts slot_len+1 cycles, with slot_len sampled when the command starts. bit_strobe is high only in the first cycle of each bit slot, and bit slots only occur with lane 0 at LP-00.
- R3: The escape commands (modes 0 to 3) drive lane 0 through LP-10, LP-00, LP-01 and LP-00, one slot each. The entry code is then sent first-bit-first on bit_val, starting from the leftmost bit as written below.
- R4: Mode encoding is 0 low-power data, 1 ultra-low power, 2 remote reset, 3 acknowledge, 4 high-speed enter, 5 high-speed leave, 6 turnaround, 7 wake. The entry codes are 11100001 (mode 0), 00011110 (mode 1), 01100010 (mode 2) and 00100001 (mode 3).
- R5: After the code of mode 2 or 3, lane 0 drives LP-10 for one slot, then LP-11, with cmd_done high in the first LP-11 cycle.
- R6: In mode 0, tx_ready is high only in the last cycle of the last bit of the code or of a byte. A byte taken in that cycle is sent LSB first in the next eight slots. If tx_valid is low there, lane 0 leaves escape mode through LP-10 to LP-11 with cmd_done.
- R7: After the code of mode 1, lane 0 rests at LP-00 with cmd_done. Mode 7 from there drives LP-10 for one slot, then LP-11 with cmd_done.
- R8: Mode 4 drives LP-01 and then LP-00 for one slot each, then HS-0 (hs=1, dp=dn=0) with cmd_done. Lane 1 follows lane 0 when hs_two_lane was high at the start, and otherwise stays at LP-11. Mode 5 from high speed returns both lanes to LP-11 in the next cycle, with cmd_done.
- R9: Mode 6 drives lane 0 through LP-10, LP-00, LP-10 and LP-00, then releases it (hiz=1), with cmd_done. Mode 7 from the released state returns to LP-11 in the next cycle, with cmd_done.
- R10: A command is accepted from LP-11 with modes 0-4 and 6, from high speed with mode 5, and from LP-00 rest or release with mode 7. Any other start raises cmd_err for one cycle in the next cycle, with no cmd_done, and leaves both lanes unchanged.
- R11: Lane 1 stays at LP-11 during escape mode and turnaround, and is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle command request |
| cmd_mode | input | 3 | Command mode (R4) |
| slot_len | input | SLOT_W | Cycles per slot minus one |
| hs_two_lane | input | 1 | Use both lanes for high speed |
| tx_data | input | 8 | Payload byte |
| tx_valid | input | 1 | Payload byte available |
| tx_ready | output | 1 | Payload byte taken this cycle if valid |
| cmd_done | output | 1 | Command reached its resting state |
| cmd_err | output | 1 | Command rejected |
| bit_strobe | output | 1 | First cycle of a bit slot |
| bit_val | output | 1 | Current bit of code or payload |
| lane_dp | output | 2 | Per-lane positive LP line level |
| lane_dn | output | 2 | Per-lane negative LP line level |
| lane_hs | output | 2 | Per-lane high-speed drive (HS-0) |
| lane_hiz | output | 2 | Per-lane released to high impedance |

## Verification
The bench checks the ordering of entry codes. A design that shifts MSB-last, or sends the payload MSB first, shows the wrong bit_val in specific slots. It checks the single-cycle window of tx_ready at the end of a code or byte: a window placed one cycle off drops or duplicates payload bytes. It runs slot lengths down to one cycle, where an off-by-one timer makes states last two cycles or vanish entirely. It issues commands from the wrong resting state, where a lax legality check would leave the lanes moving instead of pulsing cmd_err.

// File: rtl/lane_esc_pkg.sv
package lane_esc_pkg;

    localparam int CODE_W = 8;

    typedef enum logic [2:0] {
        LS_11, LS_10, LS_01, LS_00, LS_HS, LS_HIZ
    } line_e;

    typedef enum logic [2:0] {
        CMD_LPDT   = 3'd0,
        CMD_ULPS   = 3'd1,
        CMD_RST    = 3'd2,
        CMD_ACK    = 3'd3,
        CMD_HS_IN  = 3'd4,
        CMD_HS_OUT = 3'd5,
        CMD_TURN   = 3'd6,
        CMD_WAKE   = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        REST_LP11, REST_ULP, REST_HS, REST_HIZ
    } rest_e;

    typedef enum logic [1:0] {
        PH_REST, PH_SEQ, PH_CODE, PH_DATA
    } phase_e;

    typedef enum logic [1:0] {
        SQ_ESC_IN, SQ_ESC_OUT, SQ_HS_IN, SQ_TURN
    } seq_e;

    function automatic logic [1:0] seq_last(input seq_e s);
        case (s)
            SQ_ESC_IN:  return 2'd3;
            SQ_ESC_OUT: return 2'd0;
            SQ_HS_IN:   return 2'd1;
            default:    return 2'd3;
        endcase
    endfunction

    function automatic line_e seq_line(input seq_e s, input logic [1:0] idx);
        case (s)
            SQ_ESC_IN: begin
                case (idx)
                    2'd0:    return LS_10;
                    2'd1:    return LS_00;
                    2'd2:    return LS_01;
                    default: return LS_00;
                endcase
            end
            SQ_ESC_OUT: return LS_10;
            SQ_HS_IN:   return (idx == 2'd0) ? LS_01 : LS_00;
            default:    return idx[0] ? LS_00 : LS_10;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] entry_code(input cmd_e c);
        case (c)
            CMD_LPDT: return 8'b1110_0001;
            CMD_ULPS: return 8'b0001_1110;
            CMD_RST:  return 8'b0110_0010;
            default:  return 8'b0010_0001;
        endcase
    endfunction

    function automatic logic cmd_legal(input rest_e r, input cmd_e c);
        case (r)
            REST_LP11: return (c != CMD_HS_OUT) && (c != CMD_WAKE);
            REST_HS:   return c == CMD_HS_OUT;
            default:   return c == CMD_WAKE;
        endcase
    endfunction

endpackage

// File: rtl/lane_slot_timer.sv
module lane_slot_timer #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] len,
    output logic              last,
    output logic              first
);
    logic [SLOT_W-1:0] cnt_d, cnt_q;
    logic              first_d, first_q;

    always_comb begin
        cnt_d   = cnt_q;
        first_d = load;
        if (load) begin
            cnt_d = len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            first_q <= first_d;
        end
    end

    assign last  = (cnt_q == '0);
    assign first = first_q;
endmodule

// File: rtl/lane_bit_shifter.sv
module lane_bit_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         msb_first,
    input  logic         advance,
    output logic         cur,
    output logic         last
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  data_d, data_q;
    logic [IW-1:0] idx_d, idx_q;
    logic          msb_d, msb_q;

    always_comb begin
        data_d = data_q;
        idx_d  = idx_q;
        msb_d  = msb_q;
        if (load) begin
            data_d = din;
            idx_d  = '0;
            msb_d  = msb_first;
        end else if (advance) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            idx_q  <= '0;
            msb_q  <= 1'b1;
        end else begin
            data_q <= data_d;
            idx_q  <= idx_d;
            msb_q  <= msb_d;
        end
    end

    assign cur  = msb_q ? data_q[IW'(W-1) - idx_q] : data_q[idx_q];
    assign last = (idx_q == IW'(W-1));
endmodule

// File: rtl/lane_pin_map.sv
module lane_pin_map
    import lane_esc_pkg::*;
(
    input  line_e line,
    output logic  dp,
    output logic  dn,
    output logic  hs,
    output logic  hiz
);
    always_comb begin
        dp  = 1'b0;
        dn  = 1'b0;
        hs  = 1'b0;
        hiz = 1'b0;
        case (line)
            LS_11:   begin dp = 1'b1; dn = 1'b1; end
            LS_10:   dp = 1'b1;
            LS_01:   dn = 1'b1;
            LS_HS:   hs = 1'b1;
            LS_HIZ:  hiz = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lane_esc_seq.sv
module lane_esc_seq
    import lane_esc_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [2:0]        cmd_mode,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic              hs_two_lane,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic              bit_strobe,
    output logic              bit_val,
    output logic [1:0]        lane_dp,
    output logic [1:0]        lane_dn,
    output logic [1:0]        lane_hs,
    output logic [1:0]        lane_hiz
);
    localparam int LANES = 2;

    typedef struct packed {
        phase_e            phase;
        seq_e              seq;
        logic [1:0]        step;
        rest_e             rest;
        cmd_e              cmd;
        logic              two;
        logic [SLOT_W-1:0] len;
        logic              done;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic              tmr_load, tmr_last, tmr_first;
    logic [SLOT_W-1:0] tmr_len;
    logic              sh_load, sh_next, sh_msb, sh_cur, sh_last;
    logic [CODE_W-1:0] sh_byte;
    logic              byte_end;
    cmd_e              req;
    line_e             line_q [LANES];

    assign req      = cmd_e'(cmd_mode);
    assign tmr_len  = (st_q.phase == PH_REST) ? slot_len : st_q.len;
    assign byte_end = tmr_last && sh_last;
    assign tx_ready = byte_end &&
                      (st_q.phase == PH_DATA ||
                       (st_q.phase == PH_CODE && st_q.cmd == CMD_LPDT));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        tmr_load  = 1'b0;
        sh_load   = 1'b0;
        sh_next   = 1'b0;
        sh_msb    = 1'b1;
        sh_byte   = entry_code(st_q.cmd);

        case (st_q.phase)
            PH_REST: begin
                if (cmd_start) begin
                    if (!cmd_legal(st_q.rest, req)) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.cmd  = req;
                        st_d.len  = slot_len;
                        st_d.two  = hs_two_lane;
                        st_d.step = 2'd0;
                        case (req)
                            CMD_HS_IN: begin
                                st_d.phase = PH_SEQ;
                                st_d.seq   = SQ_HS_IN;
                                tmr_load   = 1'b1;
                            end
                            CMD_TURN: begin
                                st_d.phase = PH_SEQ;
                                st_d.seq   = SQ_TURN;
                                tmr_load   = 1'b1;
                            end
                            CMD_HS_OUT: begin
                                st_d.rest = REST_LP11;
                                st_d.done = 1'b1;
                            end
                            CMD_WAKE: begin
                                if (st_q.rest == REST_ULP) begin
                                    st_d.phase = PH_SEQ;
                                    st_d.seq   = SQ_ESC_OUT;
                                    tmr_load   = 1'b1;
                                end else begin
                                    st_d.rest = REST_LP11;
                                    st_d.done = 1'b1;
                                end
                            end
                            default: begin
                                st_d.phase = PH_SEQ;
                                st_d.seq   = SQ_ESC_IN;
                                tmr_load   = 1'b1;
                            end
                        endcase
                    end
                end
            end

            PH_SEQ: begin
                if (tmr_last) begin
                    if (st_q.step != seq_last(st_q.seq)) begin
                        st_d.step = st_q.step + 1'b1;
                        tmr_load  = 1'b1;
                    end else begin
                        case (st_q.seq)
                            SQ_ESC_IN: begin
                                st_d.phase = PH_CODE;
                                sh_load    = 1'b1;
                                tmr_load   = 1'b1;
                            end
                            SQ_ESC_OUT: begin
                                st_d.phase = PH_REST;
                                st_d.rest  = REST_LP11;
                                st_d.done  = 1'b1;
                            end
                            SQ_HS_IN: begin
                                st_d.phase = PH_REST;
                                st_d.rest  = REST_HS;
                                st_d.done  = 1'b1;
                            end
                            default: begin
                                st_d.phase = PH_REST;
                                st_d.rest  = REST_HIZ;
                                st_d.done  = 1'b1;
                            end
                        endcase
                    end
                end
            end

            default: begin
                if (tmr_last) begin
                    if (!sh_last) begin
                        sh_next  = 1'b1;
                        tmr_load = 1'b1;
                    end else if (st_q.cmd == CMD_LPDT && tx_valid) begin
                        st_d.phase = PH_DATA;
                        sh_load    = 1'b1;
                        sh_byte    = tx_data;
                        sh_msb     = 1'b0;
                        tmr_load   = 1'b1;
                    end else if (st_q.cmd == CMD_ULPS) begin
                        st_d.phase = PH_REST;
                        st_d.rest  = REST_ULP;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_SEQ;
                        st_d.seq   = SQ_ESC_OUT;
                        st_d.step  = 2'd0;
                        tmr_load   = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_REST, seq: SQ_ESC_IN, step: 2'd0, rest: REST_LP11,
                      cmd: CMD_LPDT, two: 1'b0, len: '0, done: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    lane_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last),
        .first (tmr_first)
    );

    lane_bit_shifter #(.W(CODE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .din       (sh_byte),
        .msb_first (sh_msb),
        .advance   (sh_next),
        .cur       (sh_cur),
        .last      (sh_last)
    );

    always_comb begin
        case (st_q.phase)
            PH_REST: begin
                case (st_q.rest)
                    REST_LP11: line_q[0] = LS_11;
                    REST_ULP:  line_q[0] = LS_00;
                    REST_HS:   line_q[0] = LS_HS;
                    default:   line_q[0] = LS_HIZ;
                endcase
            end
            PH_SEQ:  line_q[0] = seq_line(st_q.seq, st_q.step);
            default: line_q[0] = LS_00;
        endcase
        if (st_q.two && ((st_q.phase == PH_SEQ && st_q.seq == SQ_HS_IN) ||
                         (st_q.phase == PH_REST && st_q.rest == REST_HS))) begin
            line_q[1] = line_q[0];
        end else begin
            line_q[1] = LS_11;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_pin_map u_pins (
            .line (line_q[g]),
            .dp   (lane_dp[g]),
            .dn   (lane_dn[g]),
            .hs   (lane_hs[g]),
            .hiz  (lane_hiz[g])
        );
    end

    assign bit_strobe = tmr_first && (st_q.phase == PH_CODE || st_q.phase == PH_DATA);
    assign bit_val    = (st_q.phase == PH_CODE || st_q.phase == PH_DATA) && sh_cur;
    assign cmd_done   = st_q.done;
    assign cmd_err    = st_q.err;
endmodule

// File: rtl/lane_esc_chk.sv
module lane_esc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       tx_ready,
    input logic       cmd_done,
    input logic       cmd_err,
    input logic       bit_strobe,
    input logic [1:0] lane_dp,
    input logic [1:0] lane_dn,
    input logic [1:0] lane_hs,
    input logic [1:0] lane_hiz
);
    p_ready_in_lp00_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!lane_dp[0] && !lane_dn[0] && !lane_hs[0] && !lane_hiz[0]));

    p_strobe_in_lp00_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (!lane_dp[0] && !lane_dn[0] && !lane_hs[0] && !lane_hiz[0]));

    p_err_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !cmd_done);

    p_err_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(cmd_start));

    p_err_lanes_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($stable(lane_dp) && $stable(lane_dn) && $stable(lane_hs) && $stable(lane_hiz)));

    p_hs_from_lp00_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_hs[0]) |-> $past(!lane_dp[0] && !lane_dn[0]));

    p_hiz_from_lp00_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_hiz[0]) |-> $past(!lane_dp[0] && !lane_dn[0]));

    p_lane1_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_hiz[1]);
endmodule

bind lane_esc_seq lane_esc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .tx_ready   (tx_ready),
    .cmd_done   (cmd_done),
    .cmd_err    (cmd_err),
    .bit_strobe (bit_strobe),
    .lane_dp    (lane_dp),
    .lane_dn    (lane_dn),
    .lane_hs    (lane_hs),
    .lane_hiz   (lane_hiz)
);

// File: tb/lane_esc_seq_bench.sv
module lane_esc_seq_bench;
    localparam int SLOT_W = 4;
    localparam logic [3:0] E11 = 4'b1100, E10 = 4'b1000, E01 = 4'b0100;
    localparam logic [3:0] E00 = 4'b0000, EHS = 4'b0010, EHZ = 4'b0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic [2:0]        cmd_mode = 3'd0;
    logic [SLOT_W-1:0] slot_len = '0;
    logic              hs_two_lane = 1'b0;
    logic [7:0]        tx_data = 8'd0;
    logic              tx_valid = 1'b0;
    logic              tx_ready, cmd_done, cmd_err, bit_strobe, bit_val;
    logic [1:0]        lane_dp, lane_dn, lane_hs, lane_hiz;

    int n_tests = 0;
    int n_fail  = 0;
    int cur_len = 0;
    int rest_m  = 0;   // 0 LP-11, 1 ULP, 2 HS, 3 released
    bit two_m   = 1'b0;
    logic [7:0] pay [4];

    always #2 clk = ~clk;

    lane_esc_seq #(.SLOT_W(SLOT_W)) u_lane_esc_seq (.*);

    function automatic logic [3:0] obs(input int i);
        return {lane_dp[i], lane_dn[i], lane_hs[i], lane_hiz[i]};
    endfunction

    function automatic logic [7:0] code_of(input int m);
        case (m)
            0: return 8'b1110_0001;
            1: return 8'b0001_1110;
            2: return 8'b0110_0010;
            default: return 8'b0010_0001;
        endcase
    endfunction

    function automatic bit legal(input int r, input int m);
        case (r)
            0: return (m != 5) && (m != 7);
            2: return m == 5;
            default: return m == 7;
        endcase
    endfunction

    function automatic logic [3:0] rest_lane(input int r, input int ln);
        if (ln == 1) return (r == 2 && two_m) ? EHS : E11;
        case (r)
            0: return E11;
            1: return E00;
            2: return EHS;
            default: return EHZ;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string got, input string exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %s expected %s", req, got, exp);
        end
    endtask

    task automatic slot(input logic [3:0] e0, input logic [3:0] e1, input bit is_bit,
                        input logic bv, input bit rdy_last, input string req);
        bit ok = 1'b1;
        string got = "", exp = "";
        for (int c = 0; c <= cur_len; c++) begin
            logic es, er;
            es = is_bit && (c == 0);
            er = rdy_last && (c == cur_len);
            if (obs(0) !== e0 || obs(1) !== e1 || bit_strobe !== es || tx_ready !== er ||
                cmd_done !== 1'b0 || (is_bit && bit_val !== bv)) begin
                if (ok) begin
                    got = $sformatf("cyc%0d l0=%b l1=%b strb=%b rdy=%b bit=%b done=%b",
                                    c, obs(0), obs(1), bit_strobe, tx_ready, bit_val, cmd_done);
                    exp = $sformatf("l0=%b l1=%b strb=%b rdy=%b bit=%b done=0",
                                    e0, e1, es, er, bv);
                end
                ok = 1'b0;
            end
            if (c < cur_len) @(negedge clk);
        end
        chk(ok, req, got, exp);
        @(negedge clk);
    endtask

    task automatic rest_chk(input string req);
        logic [3:0] e0, e1;
        e0 = rest_lane(rest_m, 0);
        e1 = rest_lane(rest_m, 1);
        chk(obs(0) === e0 && obs(1) === e1 && cmd_done === 1'b1 && cmd_err === 1'b0, req,
            $sformatf("l0=%b l1=%b done=%b err=%b", obs(0), obs(1), cmd_done, cmd_err),
            $sformatf("l0=%b l1=%b done=1 err=0", e0, e1));
    endtask

    task automatic run_cmd(input int m, input int len, input bit two, input int nbytes);
        logic [3:0] p0, p1, l1hs;
        p0 = rest_lane(rest_m, 0);
        p1 = rest_lane(rest_m, 1);
        tx_valid = (m == 0) ? (nbytes > 0) : $urandom_range(0, 1);
        tx_data  = pay[0];
        cmd_mode = 3'(m);
        slot_len = SLOT_W'(len);
        hs_two_lane = two;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        slot_len = SLOT_W'($urandom_range(0, 3));
        hs_two_lane = $urandom_range(0, 1);
        if (!legal(rest_m, m)) begin
            chk(cmd_err === 1'b1 && cmd_done === 1'b0 && obs(0) === p0 && obs(1) === p1, "R10",
                $sformatf("err=%b done=%b l0=%b l1=%b", cmd_err, cmd_done, obs(0), obs(1)),
                $sformatf("err=1 done=0 l0=%b l1=%b", p0, p1));
            @(negedge clk);
            chk(cmd_err === 1'b0 && obs(0) === p0 && obs(1) === p1, "R10",
                $sformatf("err=%b l0=%b", cmd_err, obs(0)), $sformatf("err=0 l0=%b", p0));
            return;
        end
        cur_len = len;
        case (m)
            0, 1, 2, 3: begin
                logic [7:0] cd;
                cd = code_of(m);
                slot(E10, E11, 0, 0, 0, "R3");
                slot(E00, E11, 0, 0, 0, "R3");
                slot(E01, E11, 0, 0, 0, "R3");
                slot(E00, E11, 0, 0, 0, "R3");
                for (int k = 7; k >= 0; k--) slot(E00, E11, 1, cd[k], (m == 0) && (k == 0), "R4");
                if (m == 0) begin
                    for (int b = 0; b < nbytes; b++) begin
                        logic [7:0] cb;
                        cb = pay[b];
                        tx_valid = (b + 1 < nbytes);
                        tx_data  = pay[(b + 1) % 4];
                        for (int i = 0; i < 8; i++) slot(E00, E11, 1, cb[i], i == 7, "R6");
                    end
                end
                if (m == 1) begin
                    rest_m = 1;
                    rest_chk("R7");
                end else begin
                    slot(E10, E11, 0, 0, 0, (m == 0) ? "R6" : "R5");
                    rest_m = 0;
                    rest_chk((m == 0) ? "R6" : "R5");
                end
            end
            4: begin
                two_m = two;
                slot(E01, two ? E01 : E11, 0, 0, 0, "R8");
                slot(E00, two ? E00 : E11, 0, 0, 0, "R8");
                rest_m = 2;
                rest_chk("R8");
            end
            5: begin
                rest_m = 0;
                rest_chk("R8");
            end
            6: begin
                slot(E10, E11, 0, 0, 0, "R9");
                slot(E00, E11, 0, 0, 0, "R11");
                slot(E10, E11, 0, 0, 0, "R9");
                slot(E00, E11, 0, 0, 0, "R9");
                rest_m = 3;
                rest_chk("R9");
            end
            default: begin
                if (rest_m == 1) begin
                    slot(E10, E11, 0, 0, 0, "R7");
                    rest_m = 0;
                    rest_chk("R7");
                end else begin
                    rest_m = 0;
                    rest_chk("R9");
                end
            end
        endcase
        l1hs = 4'b0;
        @(negedge clk);
        chk(cmd_done === 1'b0 && obs(0) === rest_lane(rest_m, 0), "R2",
            $sformatf("done=%b l0=%b", cmd_done, obs(0)),
            $sformatf("done=0 l0=%b", rest_lane(rest_m, 0) | l1hs));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(obs(0) === E11 && obs(1) === E11 && !cmd_done && !cmd_err && !tx_ready && !bit_strobe,
            "R1", $sformatf("l0=%b l1=%b", obs(0), obs(1)), "l0=1100 l1=1100 flags 0");

        // directed corner cases
        run_cmd(0, 0, 0, 0);
        pay[0] = 8'hA5; pay[1] = 8'h3C;
        run_cmd(0, 2, 0, 2);
        run_cmd(1, 1, 0, 0);
        run_cmd(0, 0, 0, 0);      // illegal in ULP
        run_cmd(7, 0, 0, 0);
        run_cmd(2, 0, 0, 0);
        run_cmd(3, 3, 0, 0);
        run_cmd(4, 1, 1, 0);
        run_cmd(0, 0, 0, 0);      // illegal in HS
        run_cmd(5, 0, 0, 0);
        run_cmd(4, 0, 0, 0);
        run_cmd(5, 0, 0, 0);
        run_cmd(5, 0, 0, 0);      // illegal in LP-11
        run_cmd(7, 0, 0, 0);      // illegal in LP-11
        run_cmd(6, 2, 0, 0);
        run_cmd(4, 0, 0, 0);      // illegal while released
        run_cmd(7, 1, 0, 0);

        // constrained random
        for (int it = 0; it < 120; it++) begin
            int m, n;
            m = $urandom_range(0, 7);
            if ($urandom_range(0, 9) < 8) begin
                case (rest_m)
                    0: begin m = $urandom_range(0, 5); if (m == 5) m = 6; end
                    2: m = 5;
                    default: m = 7;
                endcase
            end
            n = $urandom_range(0, 3);
            for (int b = 0; b < 4; b++) pay[b] = 8'($urandom);
            run_cmd(m, $urandom_range(0, 3), $urandom_range(0, 1), n);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule